// File: doc/BRIEF.md
# Single-Accumulator Sequential Logic Unit

This block is a clocked arithmetic and logic unit that keeps its working value in one accumulator register. Each clock cycle a 4-bit operation code picks one action. The actions are: clear the accumulator, load it from the data input, or set it to one. They also cover adding or subtracting the input, combining it bitwise, inverting, shifting left or right by one place, incrementing, decrementing, copying the accumulator to the output register, or doing nothing. A surrounding controller supplies the operation code and the operand each cycle. It reads the result through the output register after a store, and it reads the carry and zero flags directly.

The accumulator itself is not a port. Its content becomes visible only through the store operation. The output register keeps its value between stores, so downstream logic may sample it at any time. All state changes on the rising clock edge. A synchronous active-high reset clears the state.

Top module: `accalu`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator, `dout_o`, `carry_o` and `zero_o` all become 0 at that edge, whatever the operation code is.
- R2: Code 4'b0000 makes the accumulator 0. Code 4'b0001 copies `din_i` into it. Code 4'b1111 makes it 8'h01.
- R3: Code 4'b0010 copies the accumulator into `dout_o` at the edge. The accumulator, `carry_o` and `zero_o` keep their values.
- R4: `dout_o` changes only at an edge where the code is 4'b0010 (or under reset). Every other code leaves it unchanged.
- R5: Code 4'b0011 replaces the accumulator with (acc + din) mod 256. `carry_o` becomes the carry out of bit 7.
- R6: Code 4'b0100 replaces the accumulator with (acc - din) mod 256, formed as acc + ~din + 1. `carry_o` becomes the borrow, which is 1 exactly when din > acc as unsigned values.
- R7: Code 4'b0101 stores acc AND din, code 4'b0110 stores acc OR din, and code 4'b0111 stores NOT acc.
- R8: Code 4'b1000 shifts the accumulator left by one and code 4'b1001 shifts it right by one. The vacated bit is filled with 0, and `carry_o` takes the bit shifted out (old bit 7 for left, old bit 0 for right).
- R9: Code 4'b1101 adds one and code 4'b1110 subtracts one, both modulo 256. `carry_o` becomes 1 on the FF-to-00 increment and on the 00-to-FF decrement, and 0 otherwise.
- R10: Codes 4'b1010, 4'b1011 and 4'b1100 change nothing: the accumulator, `dout_o`, `carry_o` and `zero_o` keep their values.
- R11: After every code that writes the accumulator (all but 4'b0010 and the three idle codes), `zero_o` is 1 exactly when the new accumulator value is 0. Store and idle codes leave `zero_o` unchanged.
- R12: Clear, load, set, AND, OR and invert leave `carry_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code for this cycle |
| din_i | input | 8 | Operand and load data |
| dout_o | output | 8 | Output register, written by store |
| carry_o | output | 1 | Carry or borrow flag |
| zero_o | output | 1 | Set when the last written accumulator value is zero |

## Verification
The accumulator is hidden, so a wrong accumulator value stays invisible until the next store. The store makes the bad value appear on `dout_o` one edge after the store code is applied. The bench therefore follows each interesting sequence of operations with a store. A corrupted flag appears on `carry_o` or `zero_o` one edge after the operation that set it. It also shows up later when an operation that must preserve the flag (a logic op, a load, a store or an idle code) fails to leave it alone. A spurious write to the output register shows up at once as a changed `dout_o` on an edge with no store.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned OPC_W  = 4;

    // Operation code map; the encoding is the block's external contract.
    typedef enum logic [OPC_W-1:0] {
        OPC_CLEAR = 4'b0000,
        OPC_LOAD  = 4'b0001,
        OPC_STORE = 4'b0010,
        OPC_ADD   = 4'b0011,
        OPC_SUB   = 4'b0100,
        OPC_AND   = 4'b0101,
        OPC_OR    = 4'b0110,
        OPC_INV   = 4'b0111,
        OPC_SHL   = 4'b1000,
        OPC_SHR   = 4'b1001,
        OPC_IDLEA = 4'b1010,
        OPC_IDLEB = 4'b1011,
        OPC_IDLEC = 4'b1100,
        OPC_INC   = 4'b1101,
        OPC_DEC   = 4'b1110,
        OPC_ONE   = 4'b1111
    } opcode_e;

    // Source of the next accumulator value
    typedef enum logic [2:0] {
        SRC_ZERO,
        SRC_ONE,
        SRC_DIN,
        SRC_ADDER,
        SRC_AND,
        SRC_OR,
        SRC_INV,
        SRC_SHIFT
    } src_e;

    // Second operand of the shared adder
    typedef enum logic [1:0] {
        ADDEND_DIN,
        ADDEND_NDIN,
        ADDEND_ZERO,
        ADDEND_ONES
    } addend_e;

    typedef struct packed {
        logic    acc_we;
        logic    out_we;
        logic    carry_we;
        src_e    src;
        addend_e addend;
        logic    add_cin;
        logic    borrow_mode;
        logic    shift_right;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{
        acc_we:      1'b0,
        out_we:      1'b0,
        carry_we:    1'b0,
        src:         SRC_ZERO,
        addend:      ADDEND_ZERO,
        add_cin:     1'b0,
        borrow_mode: 1'b0,
        shift_right: 1'b0
    };

    function automatic logic is_idle_code(opcode_e op);
        return (op == OPC_IDLEA) || (op == OPC_IDLEB) || (op == OPC_IDLEC);
    endfunction

endpackage

// File: rtl/accalu_decode.sv
module accalu_decode
    import accalu_pkg::*;
(
    input  opcode_e op,
    output ctrl_t   ctrl
);

    always_comb begin
        ctrl = CTRL_IDLE;
        unique case (op)
            OPC_CLEAR: begin
                ctrl.acc_we = 1'b1;
                ctrl.src    = SRC_ZERO;
            end
            OPC_LOAD: begin
                ctrl.acc_we = 1'b1;
                ctrl.src    = SRC_DIN;
            end
            OPC_STORE: begin
                ctrl.out_we = 1'b1;
            end
            OPC_ADD: begin
                ctrl.acc_we   = 1'b1;
                ctrl.carry_we = 1'b1;
                ctrl.src      = SRC_ADDER;
                ctrl.addend   = ADDEND_DIN;
            end
            OPC_SUB: begin
                ctrl.acc_we      = 1'b1;
                ctrl.carry_we    = 1'b1;
                ctrl.src         = SRC_ADDER;
                ctrl.addend      = ADDEND_NDIN;
                ctrl.add_cin     = 1'b1;
                ctrl.borrow_mode = 1'b1;
            end
            OPC_AND: begin
                ctrl.acc_we = 1'b1;
                ctrl.src    = SRC_AND;
            end
            OPC_OR: begin
                ctrl.acc_we = 1'b1;
                ctrl.src    = SRC_OR;
            end
            OPC_INV: begin
                ctrl.acc_we = 1'b1;
                ctrl.src    = SRC_INV;
            end
            OPC_SHL: begin
                ctrl.acc_we   = 1'b1;
                ctrl.carry_we = 1'b1;
                ctrl.src      = SRC_SHIFT;
            end
            OPC_SHR: begin
                ctrl.acc_we      = 1'b1;
                ctrl.carry_we    = 1'b1;
                ctrl.src         = SRC_SHIFT;
                ctrl.shift_right = 1'b1;
            end
            OPC_INC: begin
                ctrl.acc_we   = 1'b1;
                ctrl.carry_we = 1'b1;
                ctrl.src      = SRC_ADDER;
                ctrl.addend   = ADDEND_ZERO;
                ctrl.add_cin  = 1'b1;
            end
            OPC_DEC: begin
                ctrl.acc_we      = 1'b1;
                ctrl.carry_we    = 1'b1;
                ctrl.src         = SRC_ADDER;
                ctrl.addend      = ADDEND_ONES;
                ctrl.borrow_mode = 1'b1;
            end
            OPC_ONE: begin
                ctrl.acc_we = 1'b1;
                ctrl.src    = SRC_ONE;
            end
            default: ctrl = CTRL_IDLE;
        endcase
    end

endmodule

// File: rtl/accalu_exec.sv
module accalu_exec
    import accalu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] din,
    input  ctrl_t        ctrl,
    output logic [W-1:0] res,
    output logic         res_carry
);

    logic [W-1:0] addend;
    logic [W:0]   sum;
    logic [W-1:0] and_v;
    logic [W-1:0] or_v;
    logic [W-1:0] inv_v;
    logic [W-1:0] shifted;
    logic         shift_out;

    // Per-bit logic slice
    for (genvar b = 0; b < W; b++) begin : g_bitlogic
        assign and_v[b] = acc[b] & din[b];
        assign or_v[b]  = acc[b] | din[b];
        assign inv_v[b] = ~acc[b];
    end

    // One adder serves add, subtract, increment and decrement
    always_comb begin
        unique case (ctrl.addend)
            ADDEND_DIN:  addend = din;
            ADDEND_NDIN: addend = ~din;
            ADDEND_ZERO: addend = '0;
            ADDEND_ONES: addend = '1;
            default:     addend = '0;
        endcase
        sum = {1'b0, acc} + {1'b0, addend} + {{W{1'b0}}, ctrl.add_cin};
    end

    always_comb begin
        if (ctrl.shift_right) begin
            shifted   = {1'b0, acc[W-1:1]};
            shift_out = acc[0];
        end else begin
            shifted   = {acc[W-2:0], 1'b0};
            shift_out = acc[W-1];
        end
    end

    always_comb begin
        unique case (ctrl.src)
            SRC_ZERO:  res = '0;
            SRC_ONE:   res = {{(W-1){1'b0}}, 1'b1};
            SRC_DIN:   res = din;
            SRC_ADDER: res = sum[W-1:0];
            SRC_AND:   res = and_v;
            SRC_OR:    res = or_v;
            SRC_INV:   res = inv_v;
            SRC_SHIFT: res = shifted;
            default:   res = '0;
        endcase
    end

    always_comb begin
        unique case (ctrl.src)
            SRC_ADDER: res_carry = sum[W] ^ ctrl.borrow_mode;
            SRC_SHIFT: res_carry = shift_out;
            default:   res_carry = 1'b0;
        endcase
    end

endmodule

// File: rtl/accalu_state.sv
module accalu_state
    import accalu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] res,
    input  logic         res_carry,
    output logic [W-1:0] acc_q,
    output logic [W-1:0] dout_q,
    output logic         carry_q,
    output logic         zero_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            dout_q  <= '0;
            carry_q <= 1'b0;
            zero_q  <= 1'b0;
        end else begin
            if (ctrl.acc_we) begin
                acc_q  <= res;
                zero_q <= ~|res;
            end
            if (ctrl.carry_we) begin
                carry_q <= res_carry;
            end
            if (ctrl.out_we) begin
                dout_q <= acc_q;
            end
        end
    end

endmodule

// File: rtl/accalu.sv
module accalu
    import accalu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OPC_W-1:0]   op_i,
    input  logic [W-1:0]       din_i,
    output logic [W-1:0]       dout_o,
    output logic               carry_o,
    output logic               zero_o
);

    ctrl_t        ctrl;
    logic [W-1:0] res;
    logic         res_carry;
    logic [W-1:0] acc_q;
    logic [W-1:0] dout_q;
    logic         carry_q;
    logic         zero_q;

    accalu_decode u_decode (
        .op   (opcode_e'(op_i)),
        .ctrl (ctrl)
    );

    accalu_exec #(.W(W)) u_exec (
        .acc       (acc_q),
        .din       (din_i),
        .ctrl      (ctrl),
        .res       (res),
        .res_carry (res_carry)
    );

    accalu_state #(.W(W)) u_state (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .res       (res),
        .res_carry (res_carry),
        .acc_q     (acc_q),
        .dout_q    (dout_q),
        .carry_q   (carry_q),
        .zero_q    (zero_q)
    );

    assign dout_o  = dout_q;
    assign carry_o = carry_q;
    assign zero_o  = zero_q;

endmodule

// File: rtl/accalu_chk.sv
module accalu_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [3:0]   op_i,
    input logic [W-1:0] dout_o,
    input logic         carry_o,
    input logic         zero_o,
    input logic [W-1:0] acc_q
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && dout_o == '0 && !carry_o && !zero_o));

    // R3
    store_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'b0010) |=> (dout_o == $past(acc_q) && $stable(acc_q)
                               && $stable(carry_o) && $stable(zero_o)));

    // R4
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i != 4'b0010) |=> $stable(dout_o));

    // R10
    idle_code_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i inside {4'b1010, 4'b1011, 4'b1100}) |=>
            ($stable(acc_q) && $stable(dout_o) && $stable(carry_o) && $stable(zero_o)));

    // R11
    zero_track_chk: assert property (@(posedge clk) disable iff (rst)
        !(op_i inside {4'b0010, 4'b1010, 4'b1011, 4'b1100}) |=> (zero_o == (acc_q == '0)));

    // R12
    carry_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i inside {4'b0000, 4'b0001, 4'b0101, 4'b0110, 4'b0111, 4'b1111}) |=> $stable(carry_o));

    // R2
    set_one_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'b1111) |=> (acc_q == W'(1)));

    // R8
    shl_out_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'b1000) |=> (carry_o == $past(acc_q[W-1]) && acc_q[0] == 1'b0));

endmodule

bind accalu accalu_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .dout_o  (dout_o),
    .carry_o (carry_o),
    .zero_o  (zero_o),
    .acc_q   (acc_q)
);

// File: tb/accalu_bench.sv
`timescale 1ns/1ps
module accalu_bench;

    localparam logic [3:0] C_CLR = 4'b0000, C_LD  = 4'b0001, C_ST  = 4'b0010,
                           C_ADD = 4'b0011, C_SUB = 4'b0100, C_AND = 4'b0101,
                           C_OR  = 4'b0110, C_INV = 4'b0111, C_SHL = 4'b1000,
                           C_SHR = 4'b1001, C_NA  = 4'b1010, C_NB  = 4'b1011,
                           C_NC  = 4'b1100, C_INC = 4'b1101, C_DEC = 4'b1110,
                           C_ONE = 4'b1111;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op  = 4'b1010;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       carry;
    logic       zero;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    accalu u_accalu (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op),
        .din_i   (din),
        .dout_o  (dout),
        .carry_o (carry),
        .zero_o  (zero)
    );

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk1(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One operation per rising edge; sample 1 ns after the edge
    task automatic step(logic [3:0] c, logic [7:0] d);
        @(negedge clk);
        op  = c;
        din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic peek(output logic [7:0] v);
        step(C_ST, 8'hA5);
        v = dout;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rst = 1'b1;
        op  = C_LD;
        din = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        chk8("R1 dout after reset", dout, 8'h00);
        chk1("R1 carry after reset", carry, 1'b0);
        chk1("R1 zero after reset", zero, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        op  = C_NA;
        peek(v);
        chk8("R1 acc after reset", v, 8'h00);
        chk1("R11 store keeps zero flag", zero, 1'b0);
    endtask

    task automatic t_load_store();
        logic [7:0] v;
        step(C_LD, 8'h3C);
        chk8("R4 load does not write dout", dout, 8'h00);
        chk1("R11 zero after load", zero, 1'b0);
        peek(v);
        chk8("R2 R3 load then store", v, 8'h3C);
        chk1("R3 store keeps carry", carry, 1'b0);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        step(C_LD, 8'h77);
        step(C_ADD, 8'h01);
        step(C_INV, 8'h00);
        chk8("R4 dout held across ops", dout, 8'h3C);
        peek(v);
        chk8("R7 invert of 78", v, 8'h87);
    endtask

    task automatic t_add();
        logic [7:0] v;
        step(C_LD, 8'hC8);
        step(C_ADD, 8'h64);
        chk1("R5 carry out of C8+64", carry, 1'b1);
        chk1("R11 zero after C8+64", zero, 1'b0);
        peek(v);
        chk8("R5 C8+64 wraps", v, 8'h2C);
        step(C_ADD, 8'h01);
        chk1("R5 no carry 2C+01", carry, 1'b0);
        step(C_LD, 8'hFF);
        step(C_ADD, 8'h01);
        chk1("R5 carry FF+01", carry, 1'b1);
        chk1("R11 zero FF+01", zero, 1'b1);
    endtask

    task automatic t_sub();
        logic [7:0] v;
        step(C_LD, 8'h50);
        step(C_SUB, 8'h30);
        chk1("R6 no borrow 50-30", carry, 1'b0);
        peek(v);
        chk8("R6 50-30", v, 8'h20);
        step(C_SUB, 8'h21);
        chk1("R6 borrow 20-21", carry, 1'b1);
        peek(v);
        chk8("R6 20-21 wraps", v, 8'hFF);
        step(C_LD, 8'h42);
        step(C_SUB, 8'h42);
        chk1("R6 no borrow equal", carry, 1'b0);
        chk1("R11 zero after equal sub", zero, 1'b1);
    endtask

    task automatic t_logic();
        logic [7:0] v;
        step(C_LD, 8'h80);
        step(C_SHL, 8'h00);
        chk1("R8 carry gets old msb", carry, 1'b1);
        step(C_LD, 8'hF0);
        chk1("R12 load keeps carry", carry, 1'b1);
        step(C_AND, 8'h3C);
        peek(v);
        chk8("R7 F0 AND 3C", v, 8'h30);
        step(C_OR, 8'h05);
        peek(v);
        chk8("R7 30 OR 05", v, 8'h35);
        step(C_INV, 8'hFF);
        peek(v);
        chk8("R7 NOT 35", v, 8'hCA);
        chk1("R12 logic ops keep carry", carry, 1'b1);
        step(C_AND, 8'h00);
        chk1("R11 zero after AND 00", zero, 1'b1);
        chk1("R12 AND keeps carry", carry, 1'b1);
    endtask

    task automatic t_shift();
        logic [7:0] v;
        step(C_LD, 8'h81);
        step(C_SHL, 8'hFF);
        chk1("R8 shl carry", carry, 1'b1);
        peek(v);
        chk8("R8 shl zero fill", v, 8'h02);
        step(C_SHR, 8'hFF);
        chk1("R8 shr carry 0", carry, 1'b0);
        peek(v);
        chk8("R8 shr 02", v, 8'h01);
        step(C_SHR, 8'h00);
        chk1("R8 shr carry old lsb", carry, 1'b1);
        chk1("R11 zero after shr", zero, 1'b1);
    endtask

    task automatic t_incdec();
        logic [7:0] v;
        step(C_LD, 8'hFE);
        step(C_INC, 8'h00);
        chk1("R9 inc FE no carry", carry, 1'b0);
        step(C_INC, 8'h00);
        chk1("R9 inc FF carry", carry, 1'b1);
        chk1("R11 zero after wrap", zero, 1'b1);
        step(C_DEC, 8'h00);
        chk1("R9 dec 00 borrow", carry, 1'b1);
        chk1("R11 zero cleared", zero, 1'b0);
        peek(v);
        chk8("R9 dec 00 wraps", v, 8'hFF);
        step(C_DEC, 8'h00);
        chk1("R9 dec FF no borrow", carry, 1'b0);
        peek(v);
        chk8("R9 dec FF", v, 8'hFE);
    endtask

    task automatic t_const();
        logic [7:0] v;
        step(C_LD, 8'hFF);
        step(C_INC, 8'h00);
        step(C_LD, 8'h99);
        step(C_ONE, 8'h00);
        chk1("R11 zero after set", zero, 1'b0);
        chk1("R12 set keeps carry", carry, 1'b1);
        peek(v);
        chk8("R2 set gives 01", v, 8'h01);
        step(C_CLR, 8'hEE);
        chk1("R2 R11 clear sets zero", zero, 1'b1);
        chk1("R12 clear keeps carry", carry, 1'b1);
        peek(v);
        chk8("R2 clear gives 00", v, 8'h00);
    endtask

    task automatic t_idle();
        logic [7:0] v;
        step(C_LD, 8'h01);
        step(C_SHR, 8'h00);
        step(C_LD, 8'h9D);
        step(C_ST, 8'h00);
        step(C_NA, 8'h00);
        step(C_NB, 8'hFF);
        step(C_NC, 8'h13);
        chk8("R10 idle keeps dout", dout, 8'h9D);
        chk1("R10 idle keeps carry", carry, 1'b1);
        chk1("R10 idle keeps zero", zero, 1'b0);
        peek(v);
        chk8("R10 idle keeps acc", v, 8'h9D);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rst = 1'b1;
        op  = C_INC;
        @(posedge clk);
        #1;
        chk8("R1 mid reset dout", dout, 8'h00);
        chk1("R1 mid reset carry", carry, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        op  = C_NA;
    endtask

    initial begin
        t_reset();
        t_load_store();
        t_hold();
        t_add();
        t_sub();
        t_logic();
        t_shift();
        t_incdec();
        t_const();
        t_idle();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule